// File: doc/BRIEF.md
# Programmable DMA Slot Scheduler

This block hands out DMA transfer slots from a table that software fills in. Each table entry is one byte that names a channel and says whether the slot is a receive or a transmit slot. Software writes the entries through a small register port, packing four entries into each 32-bit table word. It then writes the control register with the enable bit set and the index of the last entry in use.

While the block is enabled, each pulse on `slot_req` reads the entry under an internal pointer. One cycle later the block shows that entry to the DMA core with a one-cycle `slot_vld` strobe. The pointer then moves to the next entry and returns to entry 0 after the programmed last index, so the table forms a circular schedule of any length up to the table depth.

Writing zero to the control register stops the block. Software does this before it rewrites the table. Enabling the block again always starts from entry 0.

Top module: `slot_sched_top`

## Requirements
- R1: After reset, `slot_vld` is low, the control register reads 0 and every table word reads 0.
- R2: The control register is at address 0. Bit 31 is the enable bit and bits [5:0] hold the last valid entry index. It reads back as written, and bits [30:6] read 0.
- R3: Table word n is at address 0x800 + 4*n, for n from 0 to 15, and reads back what was last written to it. Entry k of a word is in bits [8k+7:8k], and entry index 4*n+k lives in word n. Reads of any other address return 0.
- R4: A `slot_req` sampled high while the block is enabled raises `slot_vld` for exactly one cycle on the next cycle. `slot_chan` then carries bits [6:0] of the entry under the pointer, and `slot_rx` carries bit 7 of that entry (1 for receive, 0 for transmit).
- R5: Each accepted request moves the pointer forward by one. When the pointer is at or above the last index, the request returns the pointer to 0 instead.
- R6: A control write with bit 31 clear returns the pointer to 0. While the block is disabled, `slot_req` is ignored and `slot_vld` stays low.
- R7: Setting the enable bit again after a disable makes the first granted slot entry 0.
- R8: In a cycle without `slot_req`, `slot_vld` is low on the next cycle and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| slot_req | input | 1 | Request for the next transfer slot |
| slot_vld | output | 1 | Granted slot strobe, one cycle |
| slot_chan | output | 7 | Channel number of the granted slot |
| slot_rx | output | 1 | 1 for a receive slot, 0 for a transmit slot |

## Verification
A wrong pointer shows up at the very next granted slot as a wrong channel or direction. A missed wrap shows up on the request after the last index, when an entry that is not entry 0 appears. A stale enable state is visible one cycle after a request, as a strobe that should not appear or one that is missing. The bench therefore compares every strobe against a model of the table and the pointer, including runs where the last index is lowered below the current pointer.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int CHAN_W = 7;

    typedef struct packed {
        logic              rx;
        logic [CHAN_W-1:0] chan;
    } slot_entry_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [31:0]      wdata,
    output logic             en,
    output logic [IDX_W-1:0] last,
    output logic             stop
);
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] last;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        stop   = 1'b0;
        if (wr) begin
            ctrl_d.en   = wdata[31];
            ctrl_d.last = wdata[IDX_W-1:0];
            stop        = !wdata[31];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign en   = ctrl_q.en;
    assign last = ctrl_q.last;
endmodule

// File: rtl/sched_table.sv
module sched_table
    import sched_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int WIDX_W = 4,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [31:0]       wdata,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_word,
    input  logic [IDX_W-1:0]  pick_idx,
    output slot_entry_t       pick
);
    logic [31:0] tbl_d [WORDS];
    logic [31:0] tbl_q [WORDS];
    logic [31:0] pick_word;

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            tbl_d[w] = tbl_q[w];
        end
        if (wr) tbl_d[wr_idx] = wdata;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q[g] <= '0;
            else        tbl_q[g] <= tbl_d[g];
        end
    end

    always_comb begin
        rd_word   = tbl_q[rd_idx];
        pick_word = tbl_q[pick_idx[IDX_W-1:2]];
        pick      = slot_entry_t'(pick_word[8*pick_idx[1:0] +: 8]);
    end
endmodule

// File: rtl/sched_walker.sv
module sched_walker
    import sched_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stop,
    input  logic [IDX_W-1:0] last,
    input  logic             req,
    input  slot_entry_t      entry,
    output logic [IDX_W-1:0] ptr,
    output logic             vld,
    output slot_entry_t      grant
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic             vld;
        slot_entry_t      ent;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d     = walk_q;
        walk_d.vld = 1'b0;
        if (!en || stop) begin
            walk_d.ptr = '0;
        end else if (req) begin
            walk_d.vld = 1'b1;
            walk_d.ent = entry;
            walk_d.ptr = (walk_q.ptr >= last) ? '0 : walk_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign ptr   = walk_q.ptr;
    assign vld   = walk_q.vld;
    assign grant = walk_q.ent;
endmodule

// File: rtl/slot_sched_top.sv
module slot_sched_top
    import sched_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              slot_req,
    output logic              slot_vld,
    output logic [CHAN_W-1:0] slot_chan,
    output logic              slot_rx
);
    localparam int WORDS  = DEPTH / 4;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int WIDX_W = $clog2(WORDS);

    logic              hit_ctrl, hit_tbl;
    logic              en_w, stop_w;
    logic [IDX_W-1:0]  last_w, ptr_w;
    logic [31:0]       word_w;
    slot_entry_t       pick_w, grant_w;
    logic [WIDX_W-1:0] widx_w;

    always_comb begin
        hit_ctrl = (reg_addr == '0);
        hit_tbl  = reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:2] < (ADDR_W-2)'(WORDS));
        widx_w   = reg_addr[2 +: WIDX_W];
        if (hit_ctrl)     reg_rdata = {en_w, {(31-IDX_W){1'b0}}, last_w};
        else if (hit_tbl) reg_rdata = word_w;
        else              reg_rdata = '0;
    end

    sched_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_we && hit_ctrl),
        .wdata (reg_wdata),
        .en    (en_w),
        .last  (last_w),
        .stop  (stop_w)
    );

    sched_table #(.WORDS(WORDS), .WIDX_W(WIDX_W), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_we && hit_tbl),
        .wr_idx   (widx_w),
        .wdata    (reg_wdata),
        .rd_idx   (widx_w),
        .rd_word  (word_w),
        .pick_idx (ptr_w),
        .pick     (pick_w)
    );

    sched_walker #(.IDX_W(IDX_W)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_w),
        .stop  (stop_w),
        .last  (last_w),
        .req   (slot_req),
        .entry (pick_w),
        .ptr   (ptr_w),
        .vld   (slot_vld),
        .grant (grant_w)
    );

    assign slot_chan = grant_w.chan;
    assign slot_rx   = grant_w.rx;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [31:0]              reg_wdata,
    input logic                     slot_req,
    input logic                     slot_vld,
    input logic                     en,
    input logic [$clog2(DEPTH)-1:0] last,
    input logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int IDX_W = $clog2(DEPTH);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == '0);

    AST_VLD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |-> ($past(slot_req) && $past(en))); // R4
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[31]) |=> (!slot_vld && ptr == '0)); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot_req && !ctrl_wr && ptr >= last) |=> (ptr == '0)); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot_req && !ctrl_wr && ptr < last) |=> (ptr == IDX_W'($past(ptr) + 1'b1))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_req && !ctrl_wr) |=> ($stable(ptr) && !slot_vld)); // R8
endmodule

bind slot_sched_top sched_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .slot_req  (slot_req),
    .slot_vld  (slot_vld),
    .en        (en_w),
    .last      (last_w),
    .ptr       (ptr_w)
);

// File: tb/sim_slot_sched_top.sv
module sim_slot_sched_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        slot_req = 1'b0;
    logic        slot_vld;
    logic [6:0]  slot_chan;
    logic        slot_rx;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_tbl [16];
    logic        m_en = 1'b0;
    logic [5:0]  m_last = '0;
    logic [5:0]  m_ptr = '0;

    always #4 clk = ~clk;

    slot_sched_top u0 (.*);

    function automatic logic [7:0] m_ent(input logic [5:0] p);
        return m_tbl[p[5:2]][8*p[1:0] +: 8];
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return {m_en, 25'd0, m_last};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 12'h000) begin
            m_en = d[31]; m_last = d[5:0];
            if (!d[31]) m_ptr = '0;
        end else if (a[11] && a[10:2] < 9'd16) begin
            m_tbl[a[5:2]] = d;
        end
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic do_req(input string tag);
        logic [7:0] e;
        @(negedge clk);
        slot_req = 1'b1;
        @(negedge clk);
        slot_req = 1'b0;
        if (m_en) begin
            e = m_ent(m_ptr);
            chk(slot_vld === 1'b1, {tag, " R4 vld"}, {31'd0, slot_vld}, 32'd1);
            chk({slot_rx, slot_chan} === e, {tag, " R4 entry"}, {24'd0, slot_rx, slot_chan}, {24'd0, e});
            m_ptr = (m_ptr >= m_last) ? 6'd0 : m_ptr + 6'd1;
        end else begin
            chk(slot_vld === 1'b0, {tag, " R6 ignored"}, {31'd0, slot_vld}, 32'd0);
        end
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk(slot_vld === 1'b0, "R8 idle", {31'd0, slot_vld}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 16; i++) m_tbl[i] = '0;
        r = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(slot_vld === 1'b0, "R1 vld", {31'd0, slot_vld}, 32'd0);
        rd_chk(12'h000, 32'd0, "R1 ctrl");
        rd_chk(12'h800, 32'd0, "R1 word0");
        rd_chk(12'h83C, 32'd0, "R1 word15");
        // R3 typical table: TX, RX, next TX, next RX
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c;
            c = 8'(2 * i);
            wr(12'(12'h800 + 4 * i), {8'h80 | (c + 8'd1), c + 8'd1, 8'h80 | c, c});
        end
        for (int i = 0; i < 16; i++) rd_chk(12'(12'h800 + 4 * i), m_tbl[i], "R3 readback");
        rd_chk(12'h840, 32'd0, "R3 past table");
        rd_chk(12'h404, 32'd0, "R3 unmapped");
        // R2 control
        wr(12'h000, 32'h7FFF_FFFF);
        rd_chk(12'h000, 32'h0000_003F, "R2 reserved bits");
        wr(12'h000, 32'h8000_003F);
        rd_chk(12'h000, 32'h8000_003F, "R2 ctrl readback");
        // R4/R5 full walk with wrap
        for (int i = 0; i < 70; i++) do_req("R5 walk");
        idle_chk();
        // R6 disable
        wr(12'h000, 32'h0);
        rd_chk(12'h000, 32'h0, "R6 ctrl off");
        do_req("R6 off");
        do_req("R6 off");
        // R7 restart at entry 0
        wr(12'h000, 32'h8000_0005);
        for (int i = 0; i < 9; i++) do_req("R7 restart");
        // R5 last lowered below pointer
        wr(12'h000, 32'h0);
        wr(12'h000, 32'h8000_003F);
        for (int i = 0; i < 10; i++) do_req("R5 pre");
        wr(12'h000, 32'h8000_0003);
        for (int i = 0; i < 6; i++) do_req("R5 shrink");
        // random mix
        for (int it = 0; it < 600; it++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 65) do_req("R4 rnd");
            else if (sel < 78) idle_chk();
            else if (sel < 88) wr(12'(12'h800 + 4 * $urandom_range(0, 15)), $urandom());
            else if (sel < 95) wr(12'h000, {1'b1, 25'd0, 6'($urandom_range(0, 63))});
            else if (sel < 98) wr(12'h000, 32'h0);
            else rd_chk(12'h000, exp_ctrl(), "R2 rnd ctrl");
        end
        for (int i = 0; i < 16; i++) rd_chk(12'(12'h800 + 4 * i), m_tbl[i], "R3 final");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule